// File: doc/BRIEF.md
# Pipelined synchronous burst SRAM core

This block is a single-port synchronous memory with registered inputs and a registered read path. Every address, control and write-data bit is taken into an input register on the rising clock edge. The memory array is accessed from those registers in the cycle that follows. Read data then passes through an output register, so a read presented at edge k appears on the shared data bus after edge k+1.

The data bus is common to reads and writes and is split into byte lanes. A write cycle can update any subset of the lanes, and a global write updates every lane. Three chip selects decide whether a strobed cycle is for this device. An asynchronous output enable gates the bus driver. The first read after a deselected cycle is not driven onto the bus, so banks can be stacked for depth expansion without two devices fighting over the bus.

The depth is 2^ADDR_W words of LANES×LANE_W bits. ADDR_W=16 with four 8-bit lanes gives the full 64K×32 organisation. The default of ADDR_W=10 keeps elaboration small. Burst address sequencing is supplied by a separate counter block, and this core takes a plain word address on each strobe.

Top module: `sbs_pipe_sram`

## Requirements
- R1: Address, controls and write data are sampled only at the rising clock edge. Changes to the inputs between edges have no effect on the cycle already captured.
- R2: A selected read strobed at edge k shows the addressed word on `dq` from edge k+1 until edge k+2, unless R7 masks it. `dq` is not driven in the cycle after a write.
- R3: When `gw_n`=0 on a selected strobe, all lanes are written with `dq`, whatever `bw_n` and `bwe_n` hold.
- R4: When `gw_n`=1 and `bwe_n`=0, lane i (`dq[8i+7:8i]` at LANE_W=8) is written when `bw_n[i]`=0. The other lanes keep their stored contents.
- R5: When `gw_n`=1 and `bwe_n`=1, the cycle is a read and the memory is unchanged, whatever values are on `bw_n` and `dq`.
- R6: A strobe is for this device only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. Any other combination is a deselect. A deselect writes nothing, and `dq` is not driven in the following cycle.
- R7: The first read after reset, or after a deselected strobe, is not driven onto `dq`. A read following it is driven normally.
- R8: `oe_n`=1 releases `dq` at once, without waiting for a clock edge. Returning `oe_n` to 0 within a driven cycle drives the data again.
- R9: When `ads_n`=1 at an edge, no access takes place, and `dq` is not driven in the following cycle.
- R10: A read of an address strobed in the cycle just after a write to it returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all registers |
| rst_n | input | 1 | Active-low synchronous reset of the pipeline (the array is not cleared) |
| addr | input | ADDR_W | Word address, sampled on a strobe |
| ads_n | input | 1 | Active-low address strobe that starts a cycle |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| gw_n | input | 1 | Global write, active low, writes every lane |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq | inout | LANES*LANE_W | Common bidirectional data bus |

## Verification
The bench builds the core with ADDR_W=10, LANES=4 and LANE_W=8. This is the full 32-bit lane structure over a 1K-word array. Every lane-merge pattern, the global-write override and the chip-select decode behave exactly as they would at full depth, while addresses stay within a small behavioural model. The bus has a weak pull-down, so an undriven `dq` reads as zero. All stored test words are non-zero, which lets the bench tell a masked read apart from a driven one.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_DESEL = 2'd1,
      CYC_READ  = 2'd2,
      CYC_WRITE = 2'd3
   } cyc_e;
endpackage

// File: rtl/sbs_in_stage.sv
module sbs_in_stage
   import sbs_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ads_n,
   input  logic              cs1_n,
   input  logic              cs2,
   input  logic              cs3_n,
   input  logic              gw_n,
   input  logic              bwe_n,
   input  logic [LANES-1:0]  bw_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output cyc_e              kind_q,
   output logic              first_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [LANES-1:0]  be_q,
   output logic [DATA_W-1:0] data_q
);
   logic             selected;
   logic             is_wr;
   logic [LANES-1:0] be_d;
   cyc_e             kind_d;
   logic             desel_st;

   assign selected = !cs1_n && cs2 && !cs3_n;
   assign is_wr    = !gw_n || !bwe_n;

   for (genvar i = 0; i < LANES; i++) begin : g_lane_sel
      assign be_d[i] = !gw_n || (!bwe_n && !bw_n[i]);
   end

   always_comb begin
      if (ads_n)          kind_d = CYC_IDLE;
      else if (!selected) kind_d = CYC_DESEL;
      else if (is_wr)     kind_d = CYC_WRITE;
      else                kind_d = CYC_READ;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q   <= CYC_IDLE;
         first_q  <= 1'b0;
         be_q     <= '0;
         desel_st <= 1'b1;
         addr_q   <= '0;
         data_q   <= '0;
      end else begin
         kind_q  <= kind_d;
         first_q <= desel_st && (kind_d == CYC_READ);
         be_q    <= (kind_d == CYC_WRITE) ? be_d : '0;
         if (kind_d == CYC_DESEL)
            desel_st <= 1'b1;
         else if (kind_d != CYC_IDLE)
            desel_st <= 1'b0;
         if (kind_d != CYC_IDLE) begin
            addr_q <= addr;
            data_q <= din;
         end
      end
   end

   a_r3_gw_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (!ads_n && selected && !gw_n) |=> (kind_q == CYC_WRITE && be_q == '1));

   a_r6_desel_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!ads_n && !selected) |=> (kind_q == CYC_DESEL && be_q == '0));

   a_r9_idle_no_access: assert property (@(posedge clk) disable iff (!rst_n)
      ads_n |=> (kind_q == CYC_IDLE && be_q == '0));

   a_r5_read_no_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (!ads_n && selected && gw_n && bwe_n) |=> (be_q == '0));
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
   parameter int ADDR_W = 10,
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int DATA_W = LANES * LANE_W,
   localparam int DEPTH  = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANES-1:0]  we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (we[i])
            mem[addr] <= wdata[i*LANE_W +: LANE_W];
      end

      assign rdata[i*LANE_W +: LANE_W] = mem[addr];
   end
endmodule

// File: rtl/sbs_out_stage.sv
module sbs_out_stage
   import sbs_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cyc_e              kind_q,
   input  logic              first_q,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] dout_q,
   output logic              drive_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout_q  <= '0;
         drive_q <= 1'b0;
      end else begin
         drive_q <= (kind_q == CYC_READ) && !first_q;
         if (kind_q == CYC_READ)
            dout_q <= rdata;
      end
   end

   a_r2_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_q != CYC_READ) |=> $stable(dout_q));

   a_r2_no_drive_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_q == CYC_WRITE) |=> !drive_q);
endmodule

// File: rtl/sbs_pipe_sram.sv
module sbs_pipe_sram
   import sbs_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ads_n,
   input  logic              cs1_n,
   input  logic              cs2,
   input  logic              cs3_n,
   input  logic              gw_n,
   input  logic              bwe_n,
   input  logic [LANES-1:0]  bw_n,
   input  logic              oe_n,
   inout  wire  [DATA_W-1:0] dq
);
   if (ADDR_W < 1 || ADDR_W > 20) begin : g_bad_addr
      $error("sbs_pipe_sram: ADDR_W must lie in 1..20");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lanes
      $error("sbs_pipe_sram: LANES and LANE_W must be at least 1");
   end

   cyc_e              kind_q;
   logic              first_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LANES-1:0]  be_q;
   logic [DATA_W-1:0] data_q;
   logic [DATA_W-1:0] rdata;
   logic [DATA_W-1:0] dout_q;
   logic              drive_q;

   sbs_in_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_in (
      .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .cs1_n(cs1_n), .cs2(cs2),
      .cs3_n(cs3_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .addr(addr),
      .din(dq), .kind_q(kind_q), .first_q(first_q), .addr_q(addr_q),
      .be_q(be_q), .data_q(data_q)
   );

   sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
      .clk(clk), .addr(addr_q), .we(be_q), .wdata(data_q), .rdata(rdata)
   );

   sbs_out_stage #(.DATA_W(DATA_W)) u_out (
      .clk(clk), .rst_n(rst_n), .kind_q(kind_q), .first_q(first_q),
      .rdata(rdata), .dout_q(dout_q), .drive_q(drive_q)
   );

   assign dq = (!oe_n && drive_q) ? dout_q : {DATA_W{1'bz}};

   a_r7_first_read_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_q == CYC_READ && first_q) |=> !drive_q);

   a_r6_no_drive_after_desel: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_q == CYC_DESEL) |=> !drive_q);
endmodule

// File: tb/sbs_pipe_sram_tb.sv
`timescale 1ns/1ps
module sbs_pipe_sram_tb_top;
   localparam int AW = 10;
   localparam int NL = 4;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          ads_n = 1'b1, cs1_n = 1'b0, cs2 = 1'b1, cs3_n = 1'b0;
   logic          gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
   logic [NL-1:0] bw_n = '1;
   logic [DW-1:0] tb_dq = '0;
   logic          tb_drv = 1'b0;
   wire  [DW-1:0] dq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [DW-1:0] mdl [0:(1<<AW)-1];

   always #2.5 clk = ~clk;

   assign dq = tb_drv ? tb_dq : {DW{1'bz}};
   // weak pull-down: an undriven bus reads as zero
   for (genvar i = 0; i < DW; i++) begin : g_pd
      pulldown (dq[i]);
   end

   sbs_pipe_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .ads_n(ads_n), .cs1_n(cs1_n),
      .cs2(cs2), .cs3_n(cs3_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
      .oe_n(oe_n), .dq(dq)
   );

   task automatic chk(input string tag, input logic [DW-1:0] exp);
      n_chk++;
      if (dq !== exp) begin
         n_bad++;
         $display("FAIL %s: dq=%h expected %h", tag, dq, exp);
      end
   endtask

   task automatic idle();
      ads_n = 1'b1; tb_drv = 1'b0; gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1;
      cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0; oe_n = 1'b0;
   endtask

   // one strobed write; returns at the negedge after the capture edge
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic g, input logic be, input logic [NL-1:0] b);
      ads_n = 1'b0; addr = a; gw_n = g; bwe_n = be; bw_n = b;
      tb_dq = d; tb_drv = 1'b1; oe_n = 1'b1;
      @(negedge clk);
      if (!g) mdl[a] = d;
      else if (!be)
         for (int i = 0; i < NL; i++)
            if (!b[i]) mdl[a][i*8 +: 8] = d[i*8 +: 8];
   endtask

   // strobed read, then idle, then sample in the cycle after edge k+1
   task automatic rd(input logic [AW-1:0] a, input string tag, input logic [DW-1:0] exp);
      idle(); ads_n = 1'b0; addr = a;
      @(negedge clk);
      idle();
      @(negedge clk);
      chk(tag, exp);
   endtask

   task automatic t_reset();
      chk("R7 reset bus released", '0);
      rd(10'd5, "R7 first read after reset masked", '0);
   endtask

   task automatic t_gw();
      wr(10'd5, 32'hA1B2C3D4, 1'b0, 1'b1, 4'b0000);
      idle(); @(negedge clk);
      rd(10'd5, "R3 global write all lanes", mdl[5]);
      wr(10'd6, 32'h5566_7788, 1'b0, 1'b0, 4'b1111);
      idle(); @(negedge clk);
      rd(10'd6, "R3 global write overrides bw_n", 32'h5566_7788);
   endtask

   task automatic t_bytes();
      wr(10'd5, 32'h11223344, 1'b1, 1'b0, 4'b1010);
      idle(); @(negedge clk);
      rd(10'd5, "R4 byte merge lanes 0,2", 32'hA122C344);
      wr(10'd5, 32'hEE00_00FF, 1'b1, 1'b0, 4'b0110);
      idle(); @(negedge clk);
      rd(10'd5, "R4 byte merge lanes 0,3", mdl[5]);
   endtask

   task automatic t_read_only();
      // read cycle with garbage on the bus and bw_n asserted: no write
      idle(); ads_n = 1'b0; addr = 10'd5; bw_n = '0; tb_dq = 32'hDEAD_BEEF;
      tb_drv = 1'b1; oe_n = 1'b1;
      @(negedge clk);
      idle(); oe_n = 1'b1;
      @(negedge clk);
      chk("R8 oe_n high releases bus", '0);
      idle();
      rd(10'd5, "R5 read leaves memory unchanged", mdl[5]);
   endtask

   task automatic t_desel();
      for (int v = 0; v < 3; v++) begin
         idle(); ads_n = 1'b0; addr = 10'd6; gw_n = 1'b0;
         tb_dq = 32'h0BAD_0BAD; tb_drv = 1'b1; oe_n = 1'b1;
         if (v == 0) cs1_n = 1'b1;
         if (v == 1) cs2   = 1'b0;
         if (v == 2) cs3_n = 1'b1;
         @(negedge clk);
         idle();
         @(negedge clk);
         chk($sformatf("R6 no drive after deselect %0d", v), '0);
         rd(10'd6, $sformatf("R7 first read after deselect %0d", v), '0);
         rd(10'd6, $sformatf("R6 deselect did not write %0d", v), mdl[6]);
      end
   endtask

   task automatic t_idle();
      idle(); addr = 10'd6;
      @(negedge clk);
      @(negedge clk);
      chk("R9 no strobe no drive", '0);
   endtask

   task automatic t_raw();
      wr(10'd9, 32'hC0FF_EE01, 1'b0, 1'b1, 4'b1111);
      rd(10'd9, "R10 read right after write", 32'hC0FF_EE01);
   endtask

   task automatic t_async_oe();
      idle(); ads_n = 1'b0; addr = 10'd9;
      @(negedge clk);
      idle();
      @(negedge clk);
      chk("R2 read data driven", 32'hC0FF_EE01);
      oe_n = 1'b1; #0.5;
      chk("R8 async release", '0);
      oe_n = 1'b0; #0.5;
      chk("R8 async re-drive", 32'hC0FF_EE01);
      @(negedge clk);
      chk("R2 drive lasts one cycle", '0);
   endtask

   task automatic t_sample_edge();
      idle(); ads_n = 1'b0; addr = 10'd6;
      @(posedge clk); #1;
      addr = 10'd9; cs2 = 1'b0;
      @(negedge clk);
      idle();
      @(negedge clk);
      chk("R1 captured address governs", mdl[6]);
   endtask

   initial begin
      idle();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_gw();
      t_bytes();
      t_read_only();
      t_desel();
      t_idle();
      t_raw();
      t_async_oe();
      t_sample_edge();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule